// File: doc/BRIEF.md
# Debug Mode Entry and Exit Controller

This block decides whether the device is in debug mode and whether the debug pin is unlocked, and it raises a system-reset request. It does not sample the pins bit by bit. A serial front end delivers the key bits from the debug pin as single-cycle strobes. The reset generators deliver power-on, brown-out and watchdog events as single-cycle strobes as well.

The debug pin is unlocked only by a secret key. The key must arrive in full on the debug pin while the reset pin is held low. After the reset pin is released, an auto-baud lock indication enters debug mode, but only if the pin is already unlocked.

Debug mode ends on any of these events:
- software writes 0 to the debug-mode bit;
- any hardware reset cause occurs;
- the reset pin goes low;
- the debug pin is driven low while the device is stopped. This also requests a system reset.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While `rstN` is low and after its release, with no stimulus, `debugMode`, `unlocked` and `sysResetReq` are 0.
- R2: While `resetPinN` is 0, each `keyBitValid` strobe shifts in `keyBit`, most significant key bit first. On the clock after the KEY_WIDTH-th bit, `unlocked` becomes 1 if the bits equal KEY_VALUE.
- R3: A complete key that differs from KEY_VALUE leaves `unlocked` unchanged and empties the shifter. A correct key sent right after it then unlocks.
- R4: When `resetPinN` is 1, the partially received key is discarded and `keyBitValid` strobes are ignored. A key split across a reset-pin release does not unlock.
- R5: `unlocked` stays 1 through reset-pin activity, brown-out, watchdog and software writes. Only `porEvt` or `rstN` clear it.
- R6: An `autoBaudLock` strobe sets `debugMode` on the next clock only when `unlocked` is 1 and `resetPinN` is 1. Otherwise it has no effect.
- R7: `swDbgWrite` with `swDbgBit`=0 clears `debugMode` on the next clock. With `swDbgBit`=1 it changes nothing.
- R8: `porEvt`, `borEvt` or `wdtEvt` clears `debugMode` on the next clock. `porEvt` also clears `unlocked`.
- R9: `resetPinN`=0 clears `debugMode` on the next clock, and exit wins over a simultaneous entry.
- R10: When `stopMode`=1 and `dbgPin`=0 first hold together, `sysResetReq` is 1 for exactly one cycle and `debugMode` is 0 on that same cycle. No further pulse occurs until the condition lapses and returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| resetPinN | input | 1 | Synchronized level of the external reset pin, low = asserted |
| keyBitValid | input | 1 | Strobe: one key bit received on the debug pin |
| keyBit | input | 1 | Key bit value accompanying `keyBitValid` |
| autoBaudLock | input | 1 | Strobe: auto-baud character recognized on the debug pin |
| dbgPin | input | 1 | Synchronized debug pin level |
| stopMode | input | 1 | Device is in stop mode |
| swDbgWrite | input | 1 | Strobe: software writes the debug-mode bit |
| swDbgBit | input | 1 | Value written with `swDbgWrite` |
| porEvt | input | 1 | Power-on reset event strobe |
| borEvt | input | 1 | Brown-out reset event strobe |
| wdtEvt | input | 1 | Watchdog reset event strobe |
| debugMode | output | 1 | Device is in debug mode |
| unlocked | output | 1 | Debug pin feature is unlocked |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with KEY_WIDTH=12 and KEY_VALUE=12'hB3C. The short key keeps wrong-key, split-key and re-unlock sequences to a few dozen cycles each. The value is not symmetric under bit reversal, so a shifter that takes bits in the wrong order cannot match by accident. A behavioural model holds received bits in a queue and is compared with all three outputs on every clock. Directed checks cover each entry path, each exit path, their priorities, and the single-pulse rule for the stop-mode reset.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  // Strobes from mode control to the key shifter
  typedef struct packed {
    logic shiftEn;
    logic shiftClr;
  } keyCtl_t;

  // Status returned by the key shifter
  typedef struct packed {
    logic lastBit;
    logic keyMatch;
  } keyStat_t;

endpackage

// File: rtl/dbg_key_shifter.sv
module dbg_key_shifter
  import dbg_mode_pkg::*;
#(
  parameter int unsigned KEY_WIDTH = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h5A3C_96E1
) (
  input  logic     clk,
  input  logic     rstN,
  input  keyCtl_t  ctl,
  input  logic     keyBit,
  output keyStat_t stat
);

  localparam int unsigned CNT_W = $clog2(KEY_WIDTH + 1);

  logic [KEY_WIDTH-1:0] shiftQ;
  logic [CNT_W-1:0]     cntQ;
  logic [KEY_WIDTH-1:0] shiftNext;

  // MSB first: the oldest bit ends up in the top position
  assign shiftNext     = {shiftQ[KEY_WIDTH-2:0], keyBit};
  assign stat.lastBit  = (cntQ == CNT_W'(KEY_WIDTH - 1));
  assign stat.keyMatch = (shiftNext == KEY_VALUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      cntQ   <= '0;
    end else if (ctl.shiftClr) begin
      shiftQ <= '0;
      cntQ   <= '0;
    end else if (ctl.shiftEn) begin
      shiftQ <= shiftNext;
      cntQ   <= cntQ + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     resetPinN,
  input  logic     keyBitValid,
  input  logic     autoBaudLock,
  input  logic     dbgPin,
  input  logic     stopMode,
  input  logic     swDbgWrite,
  input  logic     swDbgBit,
  input  logic     porEvt,
  input  logic     borEvt,
  input  logic     wdtEvt,
  input  keyStat_t stat,
  output keyCtl_t  ctl,
  output logic     debugMode,
  output logic     unlocked,
  output logic     sysResetReq
);

  logic unlockedQ, debugQ, sysRstQ, stopLowPrevQ;
  logic keyGrant, stopLow, stopPulse, anyExit, enterReq;

  // Key bits count only while the reset pin is held low
  assign ctl.shiftEn  = ~resetPinN & keyBitValid;
  assign ctl.shiftClr = resetPinN | (ctl.shiftEn & stat.lastBit);
  assign keyGrant     = ctl.shiftEn & stat.lastBit & stat.keyMatch;

  // Debug pin low in stop mode: act on the first cycle only
  assign stopLow   = stopMode & ~dbgPin;
  assign stopPulse = stopLow & ~stopLowPrevQ;

  assign anyExit  = porEvt | borEvt | wdtEvt | ~resetPinN
                  | (swDbgWrite & ~swDbgBit) | stopPulse;
  assign enterReq = autoBaudLock & unlockedQ & resetPinN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlockedQ    <= 1'b0;
      debugQ       <= 1'b0;
      sysRstQ      <= 1'b0;
      stopLowPrevQ <= 1'b0;
    end else begin
      stopLowPrevQ <= stopLow;
      sysRstQ      <= stopPulse;
      if (porEvt)        unlockedQ <= 1'b0;
      else if (keyGrant) unlockedQ <= 1'b1;
      if (anyExit)       debugQ <= 1'b0;
      else if (enterReq) debugQ <= 1'b1;
    end
  end

  assign debugMode   = debugQ;
  assign unlocked    = unlockedQ;
  assign sysResetReq = sysRstQ;

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int unsigned KEY_WIDTH = 32,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 32'h5A3C_96E1
) (
  input  logic clk,
  input  logic rstN,
  input  logic resetPinN,
  input  logic keyBitValid,
  input  logic keyBit,
  input  logic autoBaudLock,
  input  logic dbgPin,
  input  logic stopMode,
  input  logic swDbgWrite,
  input  logic swDbgBit,
  input  logic porEvt,
  input  logic borEvt,
  input  logic wdtEvt,
  output logic debugMode,
  output logic unlocked,
  output logic sysResetReq
);

  keyCtl_t  keyCtl;
  keyStat_t keyStat;

  dbg_key_shifter #(
    .KEY_WIDTH(KEY_WIDTH),
    .KEY_VALUE(KEY_VALUE)
  ) u_shifter (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (keyCtl),
    .keyBit(keyBit),
    .stat  (keyStat)
  );

  dbg_mode_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .resetPinN   (resetPinN),
    .keyBitValid (keyBitValid),
    .autoBaudLock(autoBaudLock),
    .dbgPin      (dbgPin),
    .stopMode    (stopMode),
    .swDbgWrite  (swDbgWrite),
    .swDbgBit    (swDbgBit),
    .porEvt      (porEvt),
    .borEvt      (borEvt),
    .wdtEvt      (wdtEvt),
    .stat        (keyStat),
    .ctl         (keyCtl),
    .debugMode   (debugMode),
    .unlocked    (unlocked),
    .sysResetReq (sysResetReq)
  );

endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic resetPinN,
  input logic keyBitValid,
  input logic autoBaudLock,
  input logic dbgPin,
  input logic stopMode,
  input logic swDbgWrite,
  input logic swDbgBit,
  input logic porEvt,
  input logic borEvt,
  input logic wdtEvt,
  input logic debugMode,
  input logic unlocked,
  input logic sysResetReq
);

  // R2
  unlock_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> $past(!resetPinN && keyBitValid));

  // R5
  unlock_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && !porEvt) |=> unlocked);

  // R6
  entry_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(debugMode) |-> $past(autoBaudLock && unlocked && resetPinN));

  // R7
  sw_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swDbgWrite && !swDbgBit) |=> !debugMode);

  // R8
  por_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    porEvt |=> (!unlocked && !debugMode));

  // R8
  hw_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (borEvt || wdtEvt) |=> !debugMode);

  // R9
  pin_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resetPinN |=> !debugMode);

  // R10
  sys_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);

  // R10
  sys_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> !debugMode);

  // R10
  sys_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(stopMode && !dbgPin));

endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resetPinN   (resetPinN),
  .keyBitValid (keyBitValid),
  .autoBaudLock(autoBaudLock),
  .dbgPin      (dbgPin),
  .stopMode    (stopMode),
  .swDbgWrite  (swDbgWrite),
  .swDbgBit    (swDbgBit),
  .porEvt      (porEvt),
  .borEvt      (borEvt),
  .wdtEvt      (wdtEvt),
  .debugMode   (debugMode),
  .unlocked    (unlocked),
  .sysResetReq (sysResetReq)
);

// File: tb/tb_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_mode_ctrl;

  localparam int KW = 12;
  localparam logic [KW-1:0] KEY = 12'hB3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetPinN = 1'b1, keyBitValid = 1'b0, keyBit = 1'b0;
  logic autoBaudLock = 1'b0, dbgPin = 1'b1, stopMode = 1'b0;
  logic swDbgWrite = 1'b0, swDbgBit = 1'b0;
  logic porEvt = 1'b0, borEvt = 1'b0, wdtEvt = 1'b0;
  logic debugMode, unlocked, sysResetReq;

  always #2.5 clk = ~clk;

  dbg_mode_ctrl #(.KEY_WIDTH(KW), .KEY_VALUE(KEY)) dut (
    .clk(clk), .rstN(rstN), .resetPinN(resetPinN), .keyBitValid(keyBitValid),
    .keyBit(keyBit), .autoBaudLock(autoBaudLock), .dbgPin(dbgPin),
    .stopMode(stopMode), .swDbgWrite(swDbgWrite), .swDbgBit(swDbgBit),
    .porEvt(porEvt), .borEvt(borEvt), .wdtEvt(wdtEvt),
    .debugMode(debugMode), .unlocked(unlocked), .sysResetReq(sysResetReq));

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  bit mDbg, mUnl, mRst, mPrev;
  bit kq[$];
  bit cond, pulse, grant, exitNow, enterNow;
  longint kv;

  always @(posedge clk) begin
    if (!rstN) begin
      mDbg = 0; mUnl = 0; mRst = 0; mPrev = 0;
      kq.delete();
    end else begin
      cond  = stopMode && !dbgPin;
      pulse = cond && !mPrev;
      mPrev = cond;
      grant = 0;
      if (!resetPinN) begin
        if (keyBitValid) begin
          kq.push_back(keyBit);
          if (kq.size() == KW) begin
            kv = 0;
            foreach (kq[i]) kv = kv * 2 + longint'(kq[i]);
            if (kv == longint'(KEY)) grant = 1;
            kq.delete();
          end
        end
      end else begin
        kq.delete();
      end
      exitNow  = porEvt || borEvt || wdtEvt || !resetPinN
               || (swDbgWrite && !swDbgBit) || pulse;
      enterNow = autoBaudLock && mUnl && resetPinN;
      if (exitNow) mDbg = 0;
      else if (enterNow) mDbg = 1;
      if (porEvt) mUnl = 0;
      else if (grant) mUnl = 1;
      mRst = pulse;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(curReq, "model debugMode", int'(debugMode), int'(mDbg));
      chk(curReq, "model unlocked", int'(unlocked), int'(mUnl));
      chk(curReq, "model sysResetReq", int'(sysResetReq), int'(mRst));
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [KW-1:0] val, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      keyBitValid = 1'b1;
      keyBit = val[i];
      tick();
    end
    keyBitValid = 1'b0;
    keyBit = 1'b0;
  endtask

  task automatic pulseAb();
    autoBaudLock = 1'b1; tick(); autoBaudLock = 1'b0;
  endtask

  initial begin
    tick(2);
    chk("R1", "debugMode in reset", int'(debugMode), 0);
    chk("R1", "unlocked in reset", int'(unlocked), 0);
    chk("R1", "sysResetReq in reset", int'(sysResetReq), 0);
    rstN = 1'b1;
    tick(2);
    chk("R1", "unlocked after reset", int'(unlocked), 0);
    chk("R1", "debugMode after reset", int'(debugMode), 0);

    // R6: locked, auto-baud ignored
    curReq = "R6";
    pulseAb(); tick();
    chk("R6", "entry while locked", int'(debugMode), 0);

    // R3: wrong key, then correct key
    curReq = "R3";
    resetPinN = 1'b0; tick();
    sendBits(KEY ^ 12'h001, KW-1, 0);
    chk("R3", "wrong key", int'(unlocked), 0);
    sendBits(KEY, KW-1, 0);
    chk("R3", "correct key after wrong", int'(unlocked), 1);

    // R8: power-on clears unlock
    curReq = "R8";
    porEvt = 1'b1; tick(); porEvt = 1'b0;
    chk("R8", "unlocked after por", int'(unlocked), 0);

    // R4: split key across reset pin release, ignored strobes while high
    curReq = "R4";
    sendBits(KEY, KW-1, 6);
    resetPinN = 1'b1;
    sendBits(KEY, 5, 0);
    resetPinN = 1'b0; tick();
    sendBits(KEY, 5, 0);
    chk("R4", "split key", int'(unlocked), 0);
    // bits shifted in so far: 6 low bits; finish a wrong 12 to flush, then full key
    sendBits(KEY, 5, 0);
    chk("R4", "flush frame", int'(unlocked), 0);

    // R2: full key MSB first unlocks on the clock after the last bit
    curReq = "R2";
    sendBits(KEY, KW-1, 1);
    chk("R2", "one bit short", int'(unlocked), 0);
    sendBits(KEY, 0, 0);
    chk("R2", "full key", int'(unlocked), 1);

    // R9: entry with reset pin low is ignored
    curReq = "R9";
    pulseAb();
    chk("R9", "entry with pin low", int'(debugMode), 0);
    resetPinN = 1'b1; tick();
    curReq = "R6";
    pulseAb();
    chk("R6", "entry when unlocked", int'(debugMode), 1);

    // R7
    curReq = "R7";
    swDbgWrite = 1'b1; swDbgBit = 1'b1; tick(); swDbgWrite = 1'b0;
    chk("R7", "write 1 keeps mode", int'(debugMode), 1);
    swDbgWrite = 1'b1; swDbgBit = 1'b0; tick(); swDbgWrite = 1'b0;
    chk("R7", "write 0 exits", int'(debugMode), 0);
    chk("R5", "unlock kept after sw write", int'(unlocked), 1);
    swDbgWrite = 1'b1; swDbgBit = 1'b1; tick(); swDbgWrite = 1'b0;
    chk("R7", "write 1 does not enter", int'(debugMode), 0);

    // R9: reset pin low exits, wins over entry, unlock kept
    curReq = "R9";
    pulseAb();
    resetPinN = 1'b0; autoBaudLock = 1'b1; tick(); autoBaudLock = 1'b0;
    chk("R9", "pin low exits", int'(debugMode), 0);
    chk("R5", "unlock kept through pin", int'(unlocked), 1);
    resetPinN = 1'b1; tick();

    // R8: brown-out and watchdog exit, keep unlock
    curReq = "R8";
    pulseAb();
    borEvt = 1'b1; tick(); borEvt = 1'b0;
    chk("R8", "bor exits", int'(debugMode), 0);
    chk("R5", "unlock kept after bor", int'(unlocked), 1);
    pulseAb();
    wdtEvt = 1'b1; tick(); wdtEvt = 1'b0;
    chk("R8", "wdt exits", int'(debugMode), 0);
    chk("R5", "unlock kept after wdt", int'(unlocked), 1);
    pulseAb();
    porEvt = 1'b1; tick(); porEvt = 1'b0;
    chk("R8", "por exits", int'(debugMode), 0);
    chk("R8", "por relocks", int'(unlocked), 0);
    pulseAb();
    chk("R6", "entry after relock", int'(debugMode), 0);

    // R10: stop-mode debug pin reset
    curReq = "R10";
    resetPinN = 1'b0; tick();
    sendBits(KEY, KW-1, 0);
    resetPinN = 1'b1; tick();
    pulseAb();
    stopMode = 1'b1; tick();
    chk("R10", "stop with pin high", int'(sysResetReq), 0);
    dbgPin = 1'b0; tick();
    chk("R10", "request pulse", int'(sysResetReq), 1);
    chk("R10", "mode cleared with pulse", int'(debugMode), 0);
    tick();
    chk("R10", "pulse is single", int'(sysResetReq), 0);
    pulseAb();
    chk("R10", "held condition: no repeat, entry ok", int'(debugMode), 1);
    dbgPin = 1'b1; tick();
    dbgPin = 1'b0; tick();
    chk("R10", "second pulse", int'(sysResetReq), 1);
    chk("R10", "mode cleared again", int'(debugMode), 0);
    dbgPin = 1'b1; stopMode = 1'b0; tick(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule